// File: doc/BRIEF.md
# Command-Controlled Watchdog Timer

This block is a 32-bit down-counter seen by a host as two 16-bit count registers, a command register, an interrupt mask register and an interrupt status register. The host starts and stops counting through two separate command bits. While running, the count drops by one on each cycle that the tick enable input is high. When a tick arrives at a count of zero, the counter reloads to all ones and raises the timer-complete status bit.

The same block owns the interrupt status and mask. Status bits are cleared by writing ones to them. Other sources in the chip set status bits through a vector of single-cycle set pulses. The interrupt line is high whenever a masked status bit is pending. The count is readable at any time, and the value read is the live count.

Register select values: 0 command, 1 mask, 2 status, 3 count low half, 4 count high half. Other select values read as zero and ignore writes. In the command register, bit 0 is start and bit 1 is stop. Status bit 7 is timer-complete.

Top module: `wdt_timer`

## Requirements
- R1: After reset the timer is stopped: the command register reads 0x0002 (stop set, start clear), both count halves, mask and status read 0, and irq_o is low.
- R2: A write to the command register with bit 0 set puts the timer in the running state from the next cycle. The command register then reads 0x0001.
- R3: A write to the command register with bit 1 set and bit 0 clear stops the timer, and the command register then reads 0x0002. While stopped, the count does not change on ticks.
- R4: A command write with both bits 0 and 1 set leaves the timer running. A command write with neither bit set changes nothing.
- R5: While running, each cycle with tick_i high and no count write lowers the 32-bit count by exactly one, with borrow from the high half into the low half. A cycle with tick_i low leaves it unchanged.
- R6: A tick while running at count 0 loads 0xFFFF into both halves and sets status bit 7 in the same cycle.
- R7: A write to select 3 or 4 replaces that 16-bit half on the next cycle. It takes precedence over a tick in the same cycle and does not change the run state.
- R8: Writing to the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: A status_set_i pulse sets its bit on the next cycle, and it wins over a write-1 clear of the same bit in the same cycle.
- R10: Mask bit 15 is not writable and always reads 0. Bits 14:0 hold the written value.
- R11: irq_o is high exactly when the bitwise AND of the mask and status registers is non-zero.
- R12: Reads are combinational on rd_addr_i, and count reads return the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Register select for the read |
| rd_data_o | output | 16 | Read data for rd_addr_i |
| tick_i | input | 1 | Count enable pulse |
| status_set_i | input | 16 | Per-bit set pulses into the status register |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Directed sequences cover a small count that counts down through zero into the reload, so underflow, the status raise and the interrupt can each be seen on their own. They also cover a count of 0x00010000, which separates a correct borrow from the high half from a counter that treats the halves as separate. Command writes with start only, stop only, both bits and neither bit separate the priority between the run controls from plain bit storage. A set pulse and a clear on the same bit show which of the two wins. A long random run then mixes writes to every select, ticks, set pulses and clears against a reference model, which exposes wrong precedence between a count write and a tick.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD    = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_STATUS = 3'd2,
    SEL_CNT_LO = 3'd3,
    SEL_CNT_HI = 3'd4
  } reg_sel_e;

  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_STOP_BIT  = 1;
endpackage

// File: rtl/wdt_run_ctrl.sv
`timescale 1ns/1ps
module wdt_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_we_i,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_o <= 1'b0;
    else if (cmd_we_i && start_i)     run_o <= 1'b1;  // start wins over stop
    else if (cmd_we_i && stop_i)      run_o <= 1'b0;
  end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int unsigned REG_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [2*REG_W-1:0] cnt_o,
  output logic               uf_o
);
  localparam int unsigned CNT_W = 2 * REG_W;

  logic cnt_wr;
  logic dec;
  assign cnt_wr = lo_we_i | hi_we_i;
  assign dec    = run_i & tick_i & ~cnt_wr;
  assign uf_o   = dec & (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_wr) begin
      if (lo_we_i) cnt_o[REG_W-1:0]     <= wdata_i;
      if (hi_we_i) cnt_o[CNT_W-1:REG_W] <= wdata_i;
    end else if (uf_o) begin
      cnt_o <= '1;
    end else if (dec) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_irq_ctrl.sv
`timescale 1ns/1ps
module wdt_irq_ctrl #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned TC_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             stat_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] set_i,
  input  logic             uf_i,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] stat_o,
  output logic             irq_o
);
  logic [REG_W-2:0] mask_q;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    set_vec         = set_i;
    set_vec[TC_BIT] = set_i[TC_BIT] | uf_i;
    clr_vec         = stat_we_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_o <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i[REG_W-2:0];
      stat_o <= (stat_o & ~clr_vec) | set_vec;  // set wins
    end
  end

  assign mask_o = {1'b0, mask_q};
  assign irq_o  = |(mask_o & stat_o);
endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned TC_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              tick_i,
  input  logic [REG_W-1:0]  status_set_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * REG_W;

  logic             cmd_we, mask_we, stat_we, lo_we, hi_we;
  logic             run_q, uf;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] mask_q, status_q;

  assign cmd_we  = wr_en_i && (wr_addr_i == SEL_CMD);
  assign mask_we = wr_en_i && (wr_addr_i == SEL_MASK);
  assign stat_we = wr_en_i && (wr_addr_i == SEL_STATUS);
  assign lo_we   = wr_en_i && (wr_addr_i == SEL_CNT_LO);
  assign hi_we   = wr_en_i && (wr_addr_i == SEL_CNT_HI);

  wdt_run_ctrl u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we),
    .start_i  (wr_data_i[CMD_START_BIT]),
    .stop_i   (wr_data_i[CMD_STOP_BIT]),
    .run_o    (run_q)
  );

  wdt_counter #(.REG_W(REG_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick_i),
    .lo_we_i (lo_we),
    .hi_we_i (hi_we),
    .wdata_i (wr_data_i),
    .cnt_o   (cnt_q),
    .uf_o    (uf)
  );

  wdt_irq_ctrl #(.REG_W(REG_W), .TC_BIT(TC_BIT)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we),
    .stat_we_i (stat_we),
    .wdata_i   (wr_data_i),
    .set_i     (status_set_i),
    .uf_i      (uf),
    .mask_o    (mask_q),
    .stat_o    (status_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      SEL_CMD: begin
        rd_data_o[CMD_START_BIT] = run_q;
        rd_data_o[CMD_STOP_BIT]  = ~run_q;
      end
      SEL_MASK:   rd_data_o = mask_q;
      SEL_STATUS: rd_data_o = status_q;
      SEL_CNT_LO: rd_data_o = cnt_q[REG_W-1:0];
      SEL_CNT_HI: rd_data_o = cnt_q[CNT_W-1:REG_W];
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_timer_chk.sv
`timescale 1ns/1ps
module wdt_timer_chk #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned TC_BIT = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_q,
  input logic               tick_i,
  input logic               cnt_wr,
  input logic               start_wr,
  input logic [2*REG_W-1:0] cnt_q,
  input logic [REG_W-1:0]   mask_q,
  input logic [REG_W-1:0]   status_q,
  input logic [REG_W-1:0]   status_set_i,
  input logic               irq_o
);
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> run_q); // R2
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_wr) |=> (cnt_q == $past(cnt_q))); // R3
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_UF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !cnt_wr && cnt_q == '0) |=> (&cnt_q && status_q[TC_BIT])); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_set_i) |=> ((status_q & $past(status_set_i)) == $past(status_set_i))); // R9
  AST_MASK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q[REG_W-1]); // R10
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> !irq_o); // R11
endmodule

bind wdt_timer wdt_timer_chk #(.REG_W(REG_W), .TC_BIT(TC_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_q        (run_q),
  .tick_i       (tick_i),
  .cnt_wr       (lo_we | hi_we),
  .start_wr     (cmd_we & wr_data_i[0]),
  .cnt_q        (cnt_q),
  .mask_q       (mask_q),
  .status_q     (status_q),
  .status_set_i (status_set_i),
  .irq_o        (irq_o)
);

// File: tb/wdt_timer_tb.sv
`timescale 1ns/1ps
module wdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick = 1'b0;
  logic [15:0] set_v = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic        m_run;
  logic [31:0] m_cnt;
  logic [14:0] m_mask;
  logic [15:0] m_stat;

  always #10 clk = ~clk;

  wdt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_i(tick), .status_set_i(set_v), .irq_o(irq)
  );

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0:    return {14'd0, ~m_run, m_run};
      3'd1:    return {1'b0, m_mask};
      3'd2:    return m_stat;
      3'd3:    return m_cnt[15:0];
      3'd4:    return m_cnt[31:16];
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic model_irq();
    return |({1'b0, m_mask} & m_stat);
  endfunction

  task automatic model_step(input logic we, input logic [2:0] a, input logic [15:0] d,
                            input logic tk, input logic [15:0] s);
    logic cw, uf;
    logic [15:0] clr, setv;
    cw   = we && (a == 3'd3 || a == 3'd4);
    uf   = m_run && tk && !cw && (m_cnt == 32'd0);
    clr  = (we && a == 3'd2) ? d : 16'd0;
    setv = s | (uf ? 16'h0080 : 16'h0000);
    m_stat = (m_stat & ~clr) | setv;
    if (we && a == 3'd1) m_mask = d[14:0];
    if (we && a == 3'd3) m_cnt[15:0] = d;
    else if (we && a == 3'd4) m_cnt[31:16] = d;
    else if (m_run && tk) m_cnt = uf ? 32'hFFFF_FFFF : m_cnt - 32'd1;
    if (we && a == 3'd0) begin
      if (d[0]) m_run = 1'b1;
      else if (d[1]) m_run = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, advance model, check after the edge
  task automatic cyc(input string tag, input logic we, input logic [2:0] a,
                     input logic [15:0] d, input logic tk, input logic [15:0] s,
                     input logic [2:0] ra);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk; set_v = s; rd_addr = ra;
    model_step(we, a, d, tk, s);
    @(negedge clk);
    check(tag, "rd_data", rd_data, model_read(ra));
    check(tag, "irq", {15'd0, irq}, {15'd0, model_irq()});
  endtask

  initial begin
    #(64'd4_000_000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_run = 1'b0; m_cnt = '0; m_mask = '0; m_stat = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 5; a++) begin
      rd_addr = 3'(a);
      #1;
      check("R1", "reset read", rd_data, model_read(3'(a)));
    end
    check("R1", "reset irq", {15'd0, irq}, 16'd0);

    // R3 stopped timer ignores ticks
    cyc("R3", 0, 0, 0, 1, 0, 3'd3);
    cyc("R3", 0, 0, 0, 1, 0, 3'd4);
    // R7 load small count, R2 start
    cyc("R7", 1, 3'd3, 16'd3, 0, 0, 3'd3);
    cyc("R2", 1, 3'd0, 16'h0001, 0, 0, 3'd0);
    // R5 ticks with gaps, R6 underflow
    cyc("R5", 0, 0, 0, 1, 0, 3'd3);
    cyc("R5", 0, 0, 0, 0, 0, 3'd3);
    cyc("R5", 0, 0, 0, 1, 0, 3'd3);
    cyc("R5", 0, 0, 0, 1, 0, 3'd3);
    cyc("R6", 0, 0, 0, 1, 0, 3'd4);
    cyc("R6", 0, 0, 0, 0, 0, 3'd2);
    // R10 mask top bit, R11 irq
    cyc("R10", 1, 3'd1, 16'hFFFF, 0, 0, 3'd1);
    cyc("R11", 0, 0, 0, 0, 0, 3'd2);
    // R8 clear other bit (no effect), then clear bit 7
    cyc("R8", 1, 3'd2, 16'h0001, 0, 0, 3'd2);
    cyc("R8", 1, 3'd2, 16'h0080, 0, 0, 3'd2);
    // R9 set and clear same bit
    cyc("R9", 1, 3'd2, 16'h0100, 0, 16'h0100, 3'd2);
    cyc("R11", 1, 3'd1, 16'h0000, 0, 0, 3'd2);
    // R5 borrow across halves
    cyc("R7", 1, 3'd3, 16'h0000, 1, 0, 3'd3);
    cyc("R7", 1, 3'd4, 16'h0001, 1, 0, 3'd4);
    cyc("R5", 0, 0, 0, 1, 0, 3'd4);
    cyc("R5", 0, 0, 0, 0, 0, 3'd3);
    // R3 stop freezes, R4 both bits and no bits
    cyc("R3", 1, 3'd0, 16'h0002, 1, 0, 3'd0);
    cyc("R3", 0, 0, 0, 1, 0, 3'd3);
    cyc("R4", 1, 3'd0, 16'h0003, 1, 0, 3'd0);
    cyc("R4", 1, 3'd0, 16'h0000, 1, 0, 3'd0);
    cyc("R12", 0, 0, 0, 1, 0, 3'd3);

    // random mix, R12 live reads
    for (int i = 0; i < 4000; i++) begin
      logic we, tk;
      logic [2:0] a, ra;
      logic [15:0] d, s;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 6);
      d  = 16'($urandom);
      if (a >= 3'd3 && ($urandom % 2) == 0) d = 16'($urandom % 4);
      tk = ($urandom % 3) != 0;
      s  = (($urandom % 10) == 0) ? 16'($urandom) : 16'd0;
      ra = 3'($urandom % 6);
      cyc("R12", we, a, d, tk, s, ra);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule